// File: doc/BRIEF.md
# Signed Successive Approximation Sequencer

This block is the digital half of an 11-bit signed successive approximation converter. It owns the phase timing and the trial code fed to the switched-capacitor array. The analog side (array, comparator, sample capacitor) sits outside. Each clock the analog side returns one comparator decision.

A start pulse taken while the block is idle opens an acquisition phase. In that phase the comparator is held in its zeroing state and the input is sampled. A decision phase follows, in which one bit is tested per clock. The sign is tested first, then magnitude bits from the heaviest weight down. A final latch cycle copies the settled switch pattern into the result register and raises a one-clock done pulse.

The result is a two's-complement code from -1024 to +1023. The search lands on the largest code that does not exceed the input. An input beyond either end of the range therefore settles on the nearest end code.

Top module: `sar_seq_signed`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: A `start_i` seen high at a clock edge while idle makes `busy_o` high from that edge for exactly 17 cycles: 5 acquisition cycles, then a 12-cycle conversion made of 11 decision cycles and 1 latch cycle.
- R3: `acq_o` is high for the first 5 busy cycles only. `acq_half_o` is high only in the fifth of them, which marks the half cycle by which the acquisition window exceeds 4.5 clocks.
- R4: In the first decision cycle `trial_o` is the sign trial, code 0. A comparator decision of 1 there yields sign bit 0 (result not negative), and a decision of 0 yields sign bit 1.
- R5: In the second decision cycle `trial_o` is +512 if the sign resolved to 0, and -512 if it resolved to 1.
- R6: For an input v in -1024..+1023, `result_o` (bit 10 is the sign, two's complement) equals v.
- R7: An input above +1023 yields +1023 (011 1111 1111). An input below -1024 yields -1024 (100 0000 0000).
- R8: `done_o` is high for exactly the one cycle after the last busy cycle. `result_o` takes the new code at that same edge and holds it until the next conversion latches.
- R9: A `start_i` that arrives while `busy_o` is high is ignored: the phase timing and the result are unchanged.
- R10: `cmp_hi_i` = 1 means the input is at or above `trial_o`. The bit under test is kept on 1 and cleared on 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled at the clock edge |
| cmp_hi_i | input | 1 | Comparator decision: input at or above the trial code |
| busy_o | output | 1 | High during acquisition and conversion |
| acq_o | output | 1 | Acquisition phase; the comparator is held in zeroing |
| acq_half_o | output | 1 | Last acquisition cycle (half-cycle marker) |
| trial_o | output | 11 | Trial switch code, two's complement |
| result_o | output | 11 | Last converted code, two's complement |
| done_o | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The bench aims at both range ends and at the codes next to zero (-1, 0, +1). A design that tests the sign with the wrong polarity, or treats bit 10 as a positive weight, gets these wrong and returns codes about 1024 away from the input. Inputs beyond the range check that the search saturates instead of wrapping. A start pulse injected mid-conversion catches a controller that restarts acquisition, which would stretch `busy_o` and shift `done_o`. Cycle-exact checks on `acq_o`, `acq_half_o` and the first two trial codes expose off-by-one phase counters and a search that begins at the wrong weight.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ACQ   = 2'd1,
      PH_DEC   = 2'd2,
      PH_LATCH = 2'd3
   } phase_t;
endpackage

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
   import sar_seq_pkg::*;
#(
   parameter int ACQ_CYCLES = 5,
   parameter int DEC_STEPS  = 11,
   parameter bit HALF_MARK  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic acq_o,
   output logic acq_half_o,
   output logic load_o,
   output logic step_o,
   output logic latch_o
);
   localparam int CNT_MAX = (ACQ_CYCLES > DEC_STEPS) ? ACQ_CYCLES : DEC_STEPS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYCLES - 1);
   localparam logic [CNT_W-1:0] DEC_LAST = CNT_W'(DEC_STEPS - 1);

   if (ACQ_CYCLES < 1) begin : g_bad_acq
      $error("ACQ_CYCLES must be at least 1");
   end
   if (DEC_STEPS < 2) begin : g_bad_dec
      $error("DEC_STEPS must be at least 2");
   end

   phase_t           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (start_i) begin
               phase_d = PH_ACQ;
               cnt_d   = '0;
            end
         end
         PH_ACQ: begin
            if (cnt_q == ACQ_LAST) begin
               phase_d = PH_DEC;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         PH_DEC: begin
            if (cnt_q == DEC_LAST) begin
               phase_d = PH_LATCH;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         PH_LATCH: begin
            phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy_o  = (phase_q != PH_IDLE);
   assign acq_o   = (phase_q == PH_ACQ);
   assign load_o  = (phase_q == PH_IDLE) && start_i;
   assign step_o  = (phase_q == PH_DEC);
   assign latch_o = (phase_q == PH_LATCH);

   if (HALF_MARK) begin : g_half
      assign acq_half_o = (phase_q == PH_ACQ) && (cnt_q == ACQ_LAST);
   end else begin : g_nohalf
      assign acq_half_o = 1'b0;
   end

   // R3
   acq_to_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ACQ && cnt_q == ACQ_LAST) |=> (phase_q == PH_DEC && cnt_q == '0));

   // R9
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DEC && start_i) |=> (phase_q != PH_ACQ));

   // R2
   latch_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_LATCH) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/sar_bit_search.sv
module sar_bit_search #(
   parameter int RES_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             cmp_hi_i,
   output logic [RES_W-1:0] trial_o
);
   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   if (RES_W < 3) begin : g_bad_w
      $error("RES_W must be at least 3");
   end

   logic [RES_W-1:0] offs_q;
   logic [RES_W-1:0] sel_q;
   logic [RES_W-1:0] offs_d;

   for (genvar b = 0; b < RES_W; b++) begin : g_bit
      always_comb begin
         if (load_i)
            offs_d[b] = 1'b0;
         else if (step_i && sel_q[b] && cmp_hi_i)
            offs_d[b] = 1'b1;
         else
            offs_d[b] = offs_q[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offs_q <= '0;
         sel_q  <= '0;
      end else begin
         offs_q <= offs_d;
         if (load_i)
            sel_q <= TOP_BIT;
         else if (step_i)
            sel_q <= sel_q >> 1;
      end
   end

   assign trial_o = (offs_q | sel_q) ^ TOP_BIT;

   // R10
   keep_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && cmp_hi_i && sel_q != '0) |=> ((offs_q & $past(sel_q)) != '0));

   // R10
   clear_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !cmp_hi_i) |=> ((offs_q & $past(sel_q)) == '0));

   // R4
   one_bit_tested_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sel_q == TOP_BIT && offs_q == '0));
endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
   parameter int RES_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             latch_i,
   input  logic [RES_W-1:0] code_i,
   output logic [RES_W-1:0] result_o,
   output logic             done_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= latch_i;
         if (latch_i)
            result_o <= code_i;
      end
   end

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_i) |=> $stable(result_o));
endmodule

// File: rtl/sar_seq_signed.sv
module sar_seq_signed #(
   parameter int MAG_BITS   = 10,
   parameter int ACQ_CYCLES = 5,
   parameter bit HALF_MARK  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                cmp_hi_i,
   output logic                busy_o,
   output logic                acq_o,
   output logic                acq_half_o,
   output logic [MAG_BITS:0]   trial_o,
   output logic [MAG_BITS:0]   result_o,
   output logic                done_o
);
   localparam int RES_W = MAG_BITS + 1;

   logic load_w, step_w, latch_w;

   sar_phase_ctl #(
      .ACQ_CYCLES (ACQ_CYCLES),
      .DEC_STEPS  (RES_W),
      .HALF_MARK  (HALF_MARK)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .busy_o     (busy_o),
      .acq_o      (acq_o),
      .acq_half_o (acq_half_o),
      .load_o     (load_w),
      .step_o     (step_w),
      .latch_o    (latch_w)
   );

   sar_bit_search #(.RES_W(RES_W)) u_search (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_w),
      .step_i   (step_w),
      .cmp_hi_i (cmp_hi_i),
      .trial_o  (trial_o)
   );

   sar_result_hold #(.RES_W(RES_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .latch_i  (latch_w),
      .code_i   (trial_o),
      .result_o (result_o),
      .done_o   (done_o)
   );

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R3
   acq_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acq_o |-> busy_o);
endmodule

// File: tb/sar_seq_signed_tb_top.sv
module sar_seq_signed_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cmp_hi_i;
   logic        busy_o, acq_o, acq_half_o, done_o;
   logic [10:0] trial_o, result_o;
   int          vin = 0;
   int          vectors = 0;
   int          fails = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   // behavioural comparator
   logic signed [10:0] trial_s;
   assign trial_s  = trial_o;
   assign cmp_hi_i = (vin >= int'(trial_s));

   sar_seq_signed dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cmp_hi_i   (cmp_hi_i),
      .busy_o     (busy_o),
      .acq_o      (acq_o),
      .acq_half_o (acq_half_o),
      .trial_o    (trial_o),
      .result_o   (result_o),
      .done_o     (done_o)
   );

   function automatic int exp_code(int v);
      if (v > 1023) return 1023;
      if (v < -1024) return -1024;
      return v;
   endfunction

   function automatic int as_signed(logic [10:0] c);
      logic signed [10:0] s;
      s = c;
      return int'(s);
   endfunction

   task automatic chk(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one conversion; ign = cycle index at which to inject a start while busy (-1 none)
   task automatic run_conv(int v, int ign);
      int prev_res;
      prev_res = as_signed(result_o);
      @(negedge clk);
      vin = v;
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k <= 18; k++) begin
         if (k > 0) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
         end
         chk("R2 busy", int'(busy_o), int'(k < 17));
         chk("R3 acq", int'(acq_o), int'(k < 5));
         chk("R3 acq_half", int'(acq_half_o), int'(k == 4));
         chk("R8 done", int'(done_o), int'(k == 17));
         if (k < 17)
            chk("R8 result held", as_signed(result_o), prev_res);
         if (k == 5)
            chk("R4 sign trial", as_signed(trial_o), 0);
         if (k == 6)
            chk("R5 second trial", as_signed(trial_o), (v >= 0) ? 512 : -512);
         if (k >= 17)
            chk((v > 1023 || v < -1024) ? "R7 saturate" : "R6 R10 result",
                as_signed(result_o), exp_code(v));
         if (k == ign) start_i = 1'b1; // R9 start while busy
      end
   endtask

   initial begin
      int rv;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 done", int'(done_o), 0);
      chk("R1 result", as_signed(result_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after release", int'(busy_o), 0);

      run_conv(0, -1);
      run_conv(-1, -1);
      run_conv(1, -1);
      run_conv(1023, -1);
      run_conv(-1024, -1);
      run_conv(512, -1);
      run_conv(-513, -1);
      run_conv(2000, -1);   // R7
      run_conv(-3000, -1);  // R7
      run_conv(300, 8);     // R9 during decisions
      run_conv(-700, 2);    // R9 during acquisition
      run_conv(77, 16);     // R9 in latch cycle

      for (int n = 0; n < 40; n++) begin
         rv = int'($urandom_range(0, 2047)) - 1024;
         run_conv(rv, (n % 5 == 0) ? int'($urandom_range(1, 16)) : -1);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R2 watchdog actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule